// File: doc/BRIEF.md
# MII Transmit 4B/5B Encoder

This block sits at the transmit edge of a 100 Mbit/s physical layer. A media access controller presents frame data one nibble at a time, together with an enable and an error flag, on a 25 MHz transmit clock that never stops. Each rising edge that finds the enable high takes in one nibble. The block turns that nibble into a five-bit code group for the line, and the code group leaves through a register one cycle later.

The encoder also does the framing. The first two nibbles of every frame are replaced by the start delimiter pair. When the enable drops, the encoder closes the frame with the end delimiter pair. Between frames it sends the idle code group without a break. A data nibble that arrives with the error flag set goes out as the halt code group. Scrambling, line coding and serialization happen downstream of this block.

Top module: `mii_tx_encoder`

## Requirements
- R1: On a clock edge with `rst` high, the output becomes the idle code 5'b11111 and the framing state returns to idle.
- R2: While no frame is in progress and `tx_en` is low, the output stays at 5'b11111 whatever `txd` and `tx_er` carry.
- R3: The first nibble captured for a frame is sent as J (5'b11000) and the second as K (5'b10001). Their `txd` and `tx_er` values have no effect.
- R4: Each later captured nibble is sent through the 4B/5B table: 0→11110, 1→01001, 2→10100, 3→10101, 4→01010, 5→01011, 6→01110, 7→01111, 8→10010, 9→10011, A→10110, B→10111, C→11010, D→11011, E→11100, F→11101.
- R5: A data nibble captured with `tx_er` high is sent as the halt code group H (5'b00100) in place of its table entry.
- R6: The first edge with `tx_en` low after a frame has started produces T (5'b01101). The next edge produces R (5'b00111), and idle follows unless a new frame starts.
- R7: The code group for a nibble captured on one edge appears on `code_out` just after that same edge and holds until the next edge. The latency is one register.
- R8: `tx_en` is not sampled on the edge that produces R. A frame whose enable is high at that edge starts with J on the following edge.
- R9: If `tx_en` drops right after the J nibble, so that no K has been sent, the frame is still closed with T and then R.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 25 MHz transmit clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| tx_en | input | 1 | Transmit enable from the MAC; qualifies the data and error inputs |
| tx_er | input | 1 | Transmit error flag; forces the halt code on a data nibble |
| txd | input | 4 | Transmit nibble |
| code_out | output | 5 | Registered five-bit code group toward the line coder |

## Verification
Four behaviours are checked by the assertions on every cycle. Idle holds while the enable is low. J follows a frame start. H follows an errored data nibble. After T comes R, and after R comes idle or J. Some behaviours only the directed scenarios can show. These are the exact table value for each of the sixteen nibbles, that K follows J with arbitrary data, the short frame that closes straight after J, and a frame that starts again at once on the R edge.

// File: rtl/mtx_pkg.sv
package mtx_pkg;

    localparam int NIB_W  = 4;
    localparam int CODE_W = 5;

    localparam logic [CODE_W-1:0] CG_IDLE_C = 5'b11111;
    localparam logic [CODE_W-1:0] CG_J_C    = 5'b11000;
    localparam logic [CODE_W-1:0] CG_K_C    = 5'b10001;
    localparam logic [CODE_W-1:0] CG_T_C    = 5'b01101;
    localparam logic [CODE_W-1:0] CG_R_C    = 5'b00111;
    localparam logic [CODE_W-1:0] CG_H_C    = 5'b00100;

    // Framing state of the transmitter
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SSD2  = 2'd1,   // J sent, K pending
        ST_DATA  = 2'd2,   // frame body
        ST_ESD2  = 2'd3    // T sent, R pending
    } tx_state_e;

    // Which code group the next output register load takes
    typedef enum logic [2:0] {
        K_IDLE = 3'd0,
        K_SSD1 = 3'd1,
        K_SSD2 = 3'd2,
        K_DATA = 3'd3,
        K_HALT = 3'd4,
        K_ESD1 = 3'd5,
        K_ESD2 = 3'd6
    } code_kind_e;

    typedef struct packed {
        code_kind_e        kind;
        logic [NIB_W-1:0]  nib;
    } code_req_t;

    function automatic logic [CODE_W-1:0] enc_4b5b(input logic [NIB_W-1:0] n);
        logic [CODE_W-1:0] c;
        case (n)
            4'h0: c = 5'b11110;
            4'h1: c = 5'b01001;
            4'h2: c = 5'b10100;
            4'h3: c = 5'b10101;
            4'h4: c = 5'b01010;
            4'h5: c = 5'b01011;
            4'h6: c = 5'b01110;
            4'h7: c = 5'b01111;
            4'h8: c = 5'b10010;
            4'h9: c = 5'b10011;
            4'hA: c = 5'b10110;
            4'hB: c = 5'b10111;
            4'hC: c = 5'b11010;
            4'hD: c = 5'b11011;
            4'hE: c = 5'b11100;
            default: c = 5'b11101;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/mtx_frame_ctl.sv
module mtx_frame_ctl
    import mtx_pkg::*;
#(
    parameter int NW = NIB_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tx_en,
    input  logic          tx_er,
    input  logic [NW-1:0] txd,
    output tx_state_e     state_o,
    output code_req_t     req_o
);

    tx_state_e state_q, state_d;

    always_comb begin
        state_d     = state_q;
        req_o.kind  = K_IDLE;
        req_o.nib   = txd;
        unique case (state_q)
            ST_IDLE: begin
                if (tx_en) begin
                    req_o.kind = K_SSD1;
                    state_d    = ST_SSD2;
                end
            end
            ST_SSD2: begin
                if (tx_en) begin
                    req_o.kind = K_SSD2;
                    state_d    = ST_DATA;
                end else begin
                    req_o.kind = K_ESD1;
                    state_d    = ST_ESD2;
                end
            end
            ST_DATA: begin
                if (tx_en) begin
                    req_o.kind = tx_er ? K_HALT : K_DATA;
                end else begin
                    req_o.kind = K_ESD1;
                    state_d    = ST_ESD2;
                end
            end
            default: begin
                req_o.kind = K_ESD2;
                state_d    = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    assign state_o = state_q;

    // R6: the pending-R state lasts exactly one cycle
    a_r6_esd2_single: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ESD2) |=> (state_q == ST_IDLE));

    // R3: K pending is always entered from idle with enable high
    a_r3_ssd2_from_idle: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SSD2) |-> ($past(state_q) == ST_IDLE && $past(tx_en)));

endmodule

// File: rtl/mtx_code_sel.sv
module mtx_code_sel
    import mtx_pkg::*;
#(
    parameter int CW = CODE_W
) (
    input  code_req_t     req_i,
    output logic [CW-1:0] code_o
);

    always_comb begin
        unique case (req_i.kind)
            K_SSD1:  code_o = CG_J_C;
            K_SSD2:  code_o = CG_K_C;
            K_DATA:  code_o = enc_4b5b(req_i.nib);
            K_HALT:  code_o = CG_H_C;
            K_ESD1:  code_o = CG_T_C;
            K_ESD2:  code_o = CG_R_C;
            default: code_o = CG_IDLE_C;
        endcase
    end

endmodule

// File: rtl/mtx_code_reg.sv
module mtx_code_reg #(
    parameter int                CW        = 5,
    parameter logic [CW-1:0]     RESET_VAL = '1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] d,
    output logic [CW-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) q <= RESET_VAL;
        else     q <= d;
    end

endmodule

// File: rtl/mii_tx_encoder.sv
module mii_tx_encoder
    import mtx_pkg::*;
#(
    parameter int NW = NIB_W,
    parameter int CW = CODE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tx_en,
    input  logic          tx_er,
    input  logic [NW-1:0] txd,
    output logic [CW-1:0] code_out
);

    tx_state_e      st;
    code_req_t      req;
    logic [CW-1:0]  code_d;

    mtx_frame_ctl #(.NW(NW)) u_ctl (
        .clk     (clk),
        .rst     (rst),
        .tx_en   (tx_en),
        .tx_er   (tx_er),
        .txd     (txd),
        .state_o (st),
        .req_o   (req)
    );

    mtx_code_sel #(.CW(CW)) u_sel (
        .req_i  (req),
        .code_o (code_d)
    );

    mtx_code_reg #(.CW(CW), .RESET_VAL(CG_IDLE_C)) u_oreg (
        .clk (clk),
        .rst (rst),
        .d   (code_d),
        .q   (code_out)
    );

    // R1: reset drives idle onto the line
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (code_out == CG_IDLE_C));

    // R2: enable low outside a frame keeps the line idle
    a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && !tx_en) |=> (code_out == CG_IDLE_C));

    // R3: a frame start produces J on the next output
    a_r3_j_on_start: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && tx_en) |=> (code_out == CG_J_C));

    // R5: errored data nibble becomes H
    a_r5_halt_sub: assert property (@(posedge clk) disable iff (rst)
        (st == ST_DATA && tx_en && tx_er) |=> (code_out == CG_H_C));

    // R6: T is always followed by R
    a_r6_t_then_r: assert property (@(posedge clk) disable iff (rst)
        (code_out == CG_T_C) |=> (code_out == CG_R_C));

    // R8: after R comes idle or a new J
    a_r8_after_r: assert property (@(posedge clk) disable iff (rst)
        (code_out == CG_R_C) |=> (code_out == CG_IDLE_C || code_out == CG_J_C));

endmodule

// File: tb/mii_tx_encoder_tb.sv
module mii_tx_encoder_tb;

    localparam int CLK_PERIOD = 40;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tx_en = 1'b0;
    logic       tx_er = 1'b0;
    logic [3:0] txd = 4'h0;
    logic [4:0] code_out;

    int checks = 0;
    int failures = 0;

    localparam logic [4:0] E_IDLE = 5'b11111;
    localparam logic [4:0] E_J    = 5'b11000;
    localparam logic [4:0] E_K    = 5'b10001;
    localparam logic [4:0] E_T    = 5'b01101;
    localparam logic [4:0] E_R    = 5'b00111;
    localparam logic [4:0] E_H    = 5'b00100;

    mii_tx_encoder u_dut (
        .clk      (clk),
        .rst      (rst),
        .tx_en    (tx_en),
        .tx_er    (tx_er),
        .txd      (txd),
        .code_out (code_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [4:0] tbl(input logic [3:0] n);
        logic [4:0] t [16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101,
                               5'b01010, 5'b01011, 5'b01110, 5'b01111,
                               5'b10010, 5'b10011, 5'b10110, 5'b10111,
                               5'b11010, 5'b11011, 5'b11100, 5'b11101};
        return t[n];
    endfunction

    task automatic check(input string req, input logic [4:0] exp);
        checks++;
        if (code_out !== exp) begin
            failures++;
            $display("FAIL %s: code_out=%b expected=%b at %0t", req, code_out, exp, $time);
        end
    endtask

    // drive on falling edge, then sample just after the next rising edge
    task automatic step(input logic en, input logic er, input logic [3:0] d);
        @(negedge clk);
        tx_en = en; tx_er = er; txd = d;
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        step(1'b1, 1'b1, 4'h5);
        check("R1", E_IDLE);
        step(1'b0, 1'b0, 4'h0);
        check("R1", E_IDLE);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_idle_ignore();
        for (int i = 0; i < 6; i++) begin
            step(1'b0, i[0], 4'(i * 3));
            check("R2", E_IDLE);
        end
    endtask

    // send n nibbles; err bit i marks nibble i errored
    task automatic t_frame(input logic [79:0] nibs, input int n, input logic [19:0] err,
                           input string tag);
        for (int i = 0; i < n; i++) begin
            logic [3:0] nb;
            nb = nibs[i*4 +: 4];
            step(1'b1, err[i], nb);
            if (i == 0)      check("R3/R7", E_J);
            else if (i == 1) check("R3", E_K);
            else if (err[i]) check({"R5 ", tag}, E_H);
            else             check({"R4 ", tag}, tbl(nb));
        end
        step(1'b0, 1'b1, 4'hF);
        check("R6", E_T);
        step(1'b0, 1'b0, 4'h0);
        check("R6", E_R);
        step(1'b0, 1'b1, 4'h3);
        check("R6", E_IDLE);
    endtask

    task automatic t_all_codes();
        logic [79:0] v = '0;
        v[3:0] = 4'h5; v[7:4] = 4'hD;
        for (int i = 0; i < 16; i++) v[(i+2)*4 +: 4] = 4'(i);
        t_frame(v, 18, 20'h0, "all");
    endtask

    task automatic t_errors();
        logic [79:0] v = '0;
        for (int i = 0; i < 10; i++) v[i*4 +: 4] = 4'(9 - i);
        // errors on J nibble (ignored), and data nibbles 3 and 7
        t_frame(v, 10, 20'b0000_0000_0000_1000_1001, "err");
    endtask

    task automatic t_short();
        step(1'b1, 1'b1, 4'h2);
        check("R9", E_J);
        step(1'b0, 1'b0, 4'h0);
        check("R9", E_T);
        step(1'b0, 1'b0, 4'h0);
        check("R9", E_R);
        step(1'b0, 1'b0, 4'h0);
        check("R9", E_IDLE);
    endtask

    task automatic t_back_to_back();
        step(1'b1, 1'b0, 4'h5);  check("R3", E_J);
        step(1'b1, 1'b0, 4'h5);  check("R3", E_K);
        step(1'b1, 1'b0, 4'hA);  check("R4", tbl(4'hA));
        step(1'b0, 1'b0, 4'h0);  check("R6", E_T);
        step(1'b1, 1'b1, 4'h1);  check("R8", E_R);    // enable on the R edge is not taken
        step(1'b1, 1'b0, 4'h5);  check("R8", E_J);
        step(1'b1, 1'b0, 4'h5);  check("R8", E_K);
        step(1'b1, 1'b0, 4'h0);  check("R4", tbl(4'h0));
        step(1'b0, 1'b0, 4'h0);  check("R6", E_T);
        step(1'b0, 1'b0, 4'h0);  check("R6", E_R);
        step(1'b0, 1'b0, 4'h0);  check("R2", E_IDLE);
    endtask

    task automatic t_midframe_reset();
        step(1'b1, 1'b0, 4'h5);  check("R3", E_J);
        step(1'b1, 1'b0, 4'h5);  check("R3", E_K);
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1;
        check("R1", E_IDLE);
        @(negedge clk); rst = 1'b0; tx_en = 1'b0;
        step(1'b0, 1'b0, 4'h0);  check("R1", E_IDLE);
    endtask

    initial begin
        t_reset();
        t_idle_ignore();
        t_all_codes();
        t_errors();
        t_short();
        t_back_to_back();
        t_midframe_reset();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        failures++;
        $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule